// File: doc/BRIEF.md
# Floating-Point Compare into Condition Flags

This block compares two single-precision binary floating-point operands and writes the one-bit outcome of the compare into one of eight condition flags. A two-bit predicate code picks the relation: equal, less-than or less-or-equal. A three-bit index picks the flag that receives the result. All eight flags are held in a register and are visible at the output at all times, so a branch stage can test any of them for true or false without waiting on the comparator.

Magnitudes are ordered by one unsigned integer compare over the combined exponent and fraction bits. This works because the biased exponent sits above the fraction, so the integer order of those bits matches the magnitude order. The sign bits give a fast decision when they differ, and reverse the magnitude order when both operands are negative. NaN operands are unordered and make every predicate false. The two zeros compare equal.

Top module: `fp_cond_compare`

## Requirements
- R1: The predicate code is decoded as 2'b00 = equal, 2'b01 = less-than (A < B), 2'b10 = less-or-equal (A <= B). The flag written holds 1 when the relation is true and 0 when it is false.
- R2: A compare accepted with `cmp_valid` high writes only flag `flag_sel` (bit `flag_sel` of `cc_flags`). The new value is visible after the next rising clock edge. The other seven flags keep their values.
- R3: Predicate code 2'b11 leaves all eight flags unchanged, while `cmp_done` still pulses.
- R4: `cmp_done` is high for exactly the one cycle after each cycle with `cmp_valid` high, and is low after any cycle with `cmp_valid` low.
- R5: An operand whose exponent bits [30:23] are all ones and whose fraction bits [22:0] are nonzero is a NaN. If either operand is a NaN, the written flag is 0 for every predicate. Infinities (exponent all ones, fraction zero) are ordered normally.
- R6: +0 (32'h00000000) and -0 (32'h80000000) compare equal, and neither is less than the other.
- R7: When the signs (bit 31) differ and the operands are not both zero, the operand with sign 1 is the smaller.
- R8: When both operands are positive, A < B exactly when the unsigned value of A[30:0] is below that of B[30:0]. Equality holds when all 32 bits match.
- R9: When both operands are negative, the magnitude order is reversed: A < B exactly when A[30:0] is above B[30:0].
- R10: A synchronous, active-high `rst` clears all eight flags and `cmp_done` at the next rising edge.
- R11: In a cycle with `cmp_valid` low, the flags keep their values regardless of the operand, predicate and index inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmp_valid | input | 1 | Compare request strobe for this cycle |
| opnd_a | input | 32 | Left operand A, single precision |
| opnd_b | input | 32 | Right operand B, single precision |
| pred_code | input | 2 | Relation select: 00 equal, 01 less, 10 less-or-equal, 11 no write |
| flag_sel | input | 3 | Index of the condition flag to write |
| cc_flags | output | 8 | Registered condition flag bank |
| cmp_done | output | 1 | One-cycle pulse one edge after each accepted request |

## Verification
The hardest case to reach from the ports is a wrong value written to a flag that already held that value, because the bank then shows no change. The stimulus first sets a flag to the opposite value and then overwrites it. This makes NaN, signed-zero and negative-ordering results visible as a change of a bit. A behavioural model turns each operand into a signed integer key and compares the keys. It tracks the whole flag vector and the done pulse on every clock. Random traffic drawn from a pool of zeros, infinities, NaNs and ordinary values runs alongside the directed cases.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    localparam int unsigned SP_EXP_W   = 8;
    localparam int unsigned SP_FRAC_W  = 23;
    localparam int unsigned FLAG_COUNT = 8;

    typedef enum logic [1:0] {
        PRED_EQ  = 2'b00,
        PRED_LT  = 2'b01,
        PRED_LE  = 2'b10,
        PRED_NOP = 2'b11
    } pred_e;

endpackage

// File: rtl/fpcmp_operand_decode.sv
module fpcmp_operand_decode #(
    parameter int unsigned EXP_W  = fpcmp_pkg::SP_EXP_W,
    parameter int unsigned FRAC_W = fpcmp_pkg::SP_FRAC_W,
    localparam int unsigned MAG_W  = EXP_W + FRAC_W,
    localparam int unsigned WORD_W = MAG_W + 1
) (
    input  logic [WORD_W-1:0] word_i,
    output logic              sign_o,
    output logic              zero_o,
    output logic              nan_o,
    output logic [MAG_W-1:0]  mag_o
);

    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;

    always_comb begin
        sign_o     = word_i[WORD_W-1];
        exp_field  = word_i[MAG_W-1:FRAC_W];
        frac_field = word_i[FRAC_W-1:0];
        mag_o      = word_i[MAG_W-1:0];
        zero_o     = (mag_o == '0);
        nan_o      = (&exp_field) && (frac_field != '0);
    end

endmodule

// File: rtl/fpcmp_relation.sv
module fpcmp_relation #(
    parameter int unsigned MAG_W = fpcmp_pkg::SP_EXP_W + fpcmp_pkg::SP_FRAC_W
) (
    input  logic             a_sign_i,
    input  logic             a_zero_i,
    input  logic             a_nan_i,
    input  logic [MAG_W-1:0] a_mag_i,
    input  logic             b_sign_i,
    input  logic             b_zero_i,
    input  logic             b_nan_i,
    input  logic [MAG_W-1:0] b_mag_i,
    output logic             rel_eq_o,
    output logic             rel_lt_o,
    output logic             unord_o
);

    logic both_zero;
    logic mag_below;
    logic mag_above;
    logic mag_same;
    logic sign_split;

    always_comb begin
        both_zero  = a_zero_i && b_zero_i;
        mag_below  = (a_mag_i < b_mag_i);
        mag_above  = (b_mag_i < a_mag_i);
        mag_same   = (a_mag_i == b_mag_i);
        sign_split = (a_sign_i != b_sign_i);
        unord_o    = a_nan_i || b_nan_i;

        rel_eq_o = both_zero || (!sign_split && mag_same);

        if (both_zero) begin
            rel_lt_o = 1'b0;
        end else if (sign_split) begin
            rel_lt_o = a_sign_i;
        end else if (!a_sign_i) begin
            rel_lt_o = mag_below;
        end else begin
            rel_lt_o = mag_above;
        end
    end

endmodule

// File: rtl/fpcmp_flag_bank.sv
module fpcmp_flag_bank #(
    parameter int unsigned NUM_FLAGS = fpcmp_pkg::FLAG_COUNT,
    localparam int unsigned IDX_W = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic [1:0]           pred_i,
    input  logic [IDX_W-1:0]     idx_i,
    input  logic                 rel_eq_i,
    input  logic                 rel_lt_i,
    input  logic                 unord_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 done_o
);

    import fpcmp_pkg::*;

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
        logic                 done;
    } bank_t;

    bank_t state_d;
    bank_t state_q;
    logic  verdict;
    logic  write_en;

    always_comb begin
        state_d = state_q;

        unique case (pred_e'(pred_i))
            PRED_EQ: verdict = rel_eq_i;
            PRED_LT: verdict = rel_lt_i;
            PRED_LE: verdict = rel_lt_i || rel_eq_i;
            default: verdict = 1'b0;
        endcase
        verdict  = verdict && !unord_i;
        write_en = req_i && (pred_e'(pred_i) != PRED_NOP);

        state_d.done = req_i;
        for (int unsigned k = 0; k < NUM_FLAGS; k++) begin
            if (write_en && (idx_i == IDX_W'(k))) begin
                state_d.flags[k] = verdict;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o = state_q.flags;
    assign done_o  = state_q.done;

endmodule

// File: rtl/fp_cond_compare.sv
module fp_cond_compare #(
    parameter int unsigned EXP_W     = fpcmp_pkg::SP_EXP_W,
    parameter int unsigned FRAC_W    = fpcmp_pkg::SP_FRAC_W,
    parameter int unsigned NUM_FLAGS = fpcmp_pkg::FLAG_COUNT,
    localparam int unsigned MAG_W  = EXP_W + FRAC_W,
    localparam int unsigned WORD_W = MAG_W + 1,
    localparam int unsigned IDX_W  = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmp_valid,
    input  logic [WORD_W-1:0]    opnd_a,
    input  logic [WORD_W-1:0]    opnd_b,
    input  logic [1:0]           pred_code,
    input  logic [IDX_W-1:0]     flag_sel,
    output logic [NUM_FLAGS-1:0] cc_flags,
    output logic                 cmp_done
);

    logic [WORD_W-1:0] opnd_word [2];
    logic              dec_sign  [2];
    logic              dec_zero  [2];
    logic              dec_nan   [2];
    logic [MAG_W-1:0]  dec_mag   [2];

    logic rel_eq;
    logic rel_lt;
    logic unord;

    assign opnd_word[0] = opnd_a;
    assign opnd_word[1] = opnd_b;

    for (genvar g = 0; g < 2; g++) begin : g_decode
        fpcmp_operand_decode #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) decode_i (
            .word_i (opnd_word[g]),
            .sign_o (dec_sign[g]),
            .zero_o (dec_zero[g]),
            .nan_o  (dec_nan[g]),
            .mag_o  (dec_mag[g])
        );
    end

    fpcmp_relation #(
        .MAG_W (MAG_W)
    ) relation_i (
        .a_sign_i (dec_sign[0]),
        .a_zero_i (dec_zero[0]),
        .a_nan_i  (dec_nan[0]),
        .a_mag_i  (dec_mag[0]),
        .b_sign_i (dec_sign[1]),
        .b_zero_i (dec_zero[1]),
        .b_nan_i  (dec_nan[1]),
        .b_mag_i  (dec_mag[1]),
        .rel_eq_o (rel_eq),
        .rel_lt_o (rel_lt),
        .unord_o  (unord)
    );

    fpcmp_flag_bank #(
        .NUM_FLAGS (NUM_FLAGS)
    ) bank_i (
        .clk      (clk),
        .rst      (rst),
        .req_i    (cmp_valid),
        .pred_i   (pred_code),
        .idx_i    (flag_sel),
        .rel_eq_i (rel_eq),
        .rel_lt_i (rel_lt),
        .unord_i  (unord),
        .flags_o  (cc_flags),
        .done_o   (cmp_done)
    );

endmodule

// File: rtl/fp_cond_compare_checker.sv
module fp_cond_compare_checker (
    input logic        clk,
    input logic        rst,
    input logic        cmp_valid,
    input logic [31:0] opnd_a,
    input logic [31:0] opnd_b,
    input logic [1:0]  pred_code,
    input logic [2:0]  flag_sel,
    input logic [7:0]  cc_flags,
    input logic        cmp_done
);

    logic any_nan;
    assign any_nan = ((&opnd_a[30:23]) && (opnd_a[22:0] != '0))
                  || ((&opnd_b[30:23]) && (opnd_b[22:0] != '0));

    assert_done_follows_R4: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> cmp_done);

    assert_done_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> !cmp_done);

    assert_single_flag_R2: assert property (@(posedge clk) disable iff (rst)
        cmp_valid |=> ($countones(cc_flags ^ $past(cc_flags)) <= 1));

    assert_nop_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && pred_code == 2'b11) |=> $stable(cc_flags));

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
        !cmp_valid |=> $stable(cc_flags));

    assert_nan_false_R5: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && pred_code != 2'b11 && any_nan) |=> !cc_flags[$past(flag_sel)]);

    assert_reset_clears_R10: assert property (@(posedge clk)
        rst |=> (cc_flags == 8'h00 && !cmp_done));

endmodule

bind fp_cond_compare fp_cond_compare_checker chk_i (
    .clk       (clk),
    .rst       (rst),
    .cmp_valid (cmp_valid),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .pred_code (pred_code),
    .flag_sel  (flag_sel),
    .cc_flags  (cc_flags),
    .cmp_done  (cmp_done)
);

// File: tb/fp_cond_compare_tb_top.sv
module fp_cond_compare_tb_top;

    localparam logic [31:0] P_ONE  = 32'h3F800000;
    localparam logic [31:0] P_TWO  = 32'h40000000;
    localparam logic [31:0] N_ONE  = 32'hBF800000;
    localparam logic [31:0] N_TWO  = 32'hC0000000;
    localparam logic [31:0] P_ZERO = 32'h00000000;
    localparam logic [31:0] N_ZERO = 32'h80000000;
    localparam logic [31:0] P_INF  = 32'h7F800000;
    localparam logic [31:0] Q_NAN  = 32'h7FC00000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmp_valid = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  pred_code = '0;
    logic [2:0]  flag_sel = '0;
    logic [7:0]  cc_flags;
    logic        cmp_done;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   finished = 0;
    logic [7:0] exp_flags = '0;
    logic       exp_done  = 1'b0;

    always #4 clk = ~clk;

    fp_cond_compare dut_i (
        .clk       (clk),
        .rst       (rst),
        .cmp_valid (cmp_valid),
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .pred_code (pred_code),
        .flag_sel  (flag_sel),
        .cc_flags  (cc_flags),
        .cmp_done  (cmp_done)
    );

    function automatic bit is_nan(logic [31:0] w);
        return (w[30:23] == 8'hFF) && (w[22:0] != 0);
    endfunction

    function automatic longint key_of(logic [31:0] w);
        longint m = longint'(w[30:0]);
        return w[31] ? -m : m;
    endfunction

    function automatic bit model_result(logic [31:0] a, logic [31:0] b, logic [1:0] p);
        longint ka = key_of(a);
        longint kb = key_of(b);
        if (is_nan(a) || is_nan(b)) return 1'b0;
        case (p)
            2'b00:   return ka == kb;
            2'b01:   return ka < kb;
            default: return ka <= kb;
        endcase
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Drive one cycle at the falling edge, advance the model, check one cycle later.
    task automatic cycle(input bit v, input logic [31:0] a, input logic [31:0] b,
                         input logic [1:0] p, input logic [2:0] s, input bit r,
                         input string tag);
        rst       = r;
        cmp_valid = v;
        opnd_a    = a;
        opnd_b    = b;
        pred_code = p;
        flag_sel  = s;
        if (r) begin
            exp_flags = '0;
            exp_done  = 1'b0;
        end else begin
            exp_done = v;
            if (v && p != 2'b11) exp_flags[s] = model_result(a, b, p);
        end
        @(negedge clk);
        n_checks++;
        if (cc_flags !== exp_flags || cmp_done !== exp_done) begin
            n_fail++;
            $display("FAIL %s: flags=%b done=%b expected flags=%b done=%b",
                     tag, cc_flags, cmp_done, exp_flags, exp_done);
        end
    endtask

    function automatic logic [31:0] pick(int unsigned r);
        case (r % 10)
            0: return P_ONE;
            1: return N_ONE;
            2: return P_TWO;
            3: return N_TWO;
            4: return P_ZERO;
            5: return N_ZERO;
            6: return P_INF;
            7: return Q_NAN;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run hung, actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        cycle(0, 0, 0, 0, 0, 1, "R10 reset");
        cycle(0, 0, 0, 0, 0, 1, "R10 reset");
        cycle(1, P_ONE, P_ONE, 2'b00, 3'd0, 0, "R1 eq true");
        cycle(1, P_ONE, P_TWO, 2'b01, 3'd1, 0, "R8 lt positive");
        cycle(1, P_TWO, P_ONE, 2'b01, 3'd2, 0, "R8 lt false");
        cycle(1, P_ONE, P_ONE, 2'b10, 3'd3, 0, "R1 le equal");
        cycle(1, N_TWO, N_ONE, 2'b01, 3'd4, 0, "R9 negative order");
        cycle(1, N_ONE, N_TWO, 2'b01, 3'd0, 0, "R9 reversed false");
        cycle(1, N_ONE, P_ONE, 2'b01, 3'd6, 0, "R7 sign split");
        cycle(1, P_ONE, N_ONE, 2'b01, 3'd1, 0, "R7 sign split false");
        cycle(1, P_ZERO, N_ZERO, 2'b00, 3'd2, 0, "R6 zeros equal");
        cycle(1, N_ZERO, P_ZERO, 2'b01, 3'd6, 0, "R6 zero not less");
        cycle(1, N_ZERO, P_ZERO, 2'b10, 3'd7, 0, "R6 zero le");
        cycle(1, Q_NAN, Q_NAN, 2'b00, 3'd3, 0, "R5 nan eq false");
        cycle(1, P_ONE, P_ONE, 2'b10, 3'd3, 0, "R2 rewrite flag");
        cycle(1, P_INF, Q_NAN, 2'b10, 3'd3, 0, "R5 nan le false");
        cycle(1, P_ONE, P_INF, 2'b01, 3'd5, 0, "R5 inf ordered");
        cycle(1, P_TWO, P_ONE, 2'b11, 3'd7, 0, "R3 nop holds");
        cycle(0, P_TWO, P_ONE, 2'b00, 3'd7, 0, "R11 idle holds");
        cycle(0, Q_NAN, P_ONE, 2'b01, 3'd5, 0, "R4 done low");
        cycle(1, P_ONE, P_ONE, 2'b00, 3'd2, 0, "R4 done pulse");
        cycle(1, P_ONE, P_ONE, 2'b00, 3'd2, 0, "R4 back to back");
        for (int i = 0; i < 400; i++) begin
            cycle(bit'($urandom_range(0, 3) != 0), pick($urandom), pick($urandom),
                  2'($urandom), 3'($urandom), 0, "R1 random");
        end
        cycle(1, P_ONE, P_TWO, 2'b01, 3'd0, 1, "R10 reset mid-run");
        cycle(0, 0, 0, 0, 0, 0, "R10 after reset");
        finish_run();
    end

endmodule